// File: doc/BRIEF.md
# Block-Mode DMA Channel Sequencer

This block is one DMA channel that copies a block of 32-bit words between system memory and a peripheral data port. Software loads three registers (a start address, a block size and a channel control word) through a simple write strobe. Writing a control word with the launch bit set starts the job. The channel then moves each word over a valid/ready memory port and a pair of peripheral FIFO ports. It advances the address register by four bytes per word. At the end it drops the busy bit and pulses its interrupt for one cycle.

The block size register holds two 16-bit halves, and the word total is their product. Only two control words start a transfer. One copies memory to the peripheral and the other copies the peripheral to memory. Any other control word with the launch bit set is refused. A refused launch moves nothing, but it still clears the busy bit and raises the interrupt, so software always sees a completion. While a job runs, the registers are locked. The one exception is a control write with the launch bit clear, which stops the job once the word in flight is done.

Top module: `blk_dma_chan`

## Requirements
- R1: After reset, the address, block and control registers read zero, no request is raised on any port, and the interrupt is low.
- R2: A launched job moves exactly (block[31:16] × block[15:0]) words.
- R3: A control write that has bit 24 set clears bits [1:0] of the address register. Memory accesses use that aligned address and then step by 4 per word.
- R4: The control value 0x01000201 reads each word from memory and then offers it unchanged on the outbound peripheral port, in ascending address order.
- R5: The control value 0x01000200 takes each word from the inbound peripheral port and writes it to memory, in ascending address order.
- R6: At the clock edge where the last word is accepted, control bit 24 clears and the address register becomes the aligned start plus 4 × the number of words. The interrupt is high for exactly the following cycle.
- R7: A control write with bit 24 set whose value is neither supported encoding makes no access. In the next cycle the control register reads back the written value with bit 24 clear, and the interrupt pulses.
- R8: A supported encoding with a word total of zero completes at once, exactly like R7, with no access.
- R9: While bit 24 is set, writes to the address and block registers are ignored, and so are control writes that keep bit 24 set. The job runs to its full length.
- R10: A control write with bit 24 clear while busy finishes the word in flight and then completes as in R6 with the reduced count. The other control bits are kept.
- R11: A memory request holds its address, direction and write data until accepted. An outbound peripheral word holds its data until accepted.
- R12: A control write with bit 24 clear while idle is stored as written and starts nothing; no interrupt follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 2 | Register select: 0 address, 1 block, 2 control |
| cfg_wr_data | input | 32 | Register write value |
| addr_reg | output | 32 | Current address register |
| blk_reg | output | 32 | Block size register |
| ctrl_reg | output | 32 | Control register, bit 24 is busy |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the request (read data valid) |
| mem_rdata | input | 32 | Memory read data |
| pout_valid | output | 1 | Outbound peripheral word valid |
| pout_data | output | 32 | Outbound peripheral word |
| pout_ready | input | 1 | Peripheral accepts the outbound word |
| pin_valid | input | 1 | Inbound peripheral word valid |
| pin_data | input | 32 | Inbound peripheral word |
| pin_ready | output | 1 | Channel accepts the inbound word |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The bench drives an unaligned start address. A design that skips alignment would access memory off the word grid and end on the wrong final address. It also launches jobs whose block halves differ, under stalls on every port. A design that adds the halves instead of multiplying them, or that repeats or drops a word under back-pressure, would deliver the wrong count or the wrong data. An unknown control word and a zero-size job must both complete without touching any port. A design that starts anyway would leave bit 24 set, or would show accesses with no interrupt. Two further cases check writes made while busy. Ignored writes must not change the block register or the length, and an abort made during a stalled fetch must stop after exactly one word with the address and interrupt updated.

// File: rtl/blk_dma_pkg.sv
package blk_dma_pkg;

    localparam int REG_W      = 32;
    localparam int HALF_W     = REG_W / 2;
    localparam int BUSY_BIT   = 24;
    localparam int DIR_BIT    = 0;
    localparam int WORD_BYTES = 4;

    localparam logic [REG_W-1:0] CTRL_MEM2DEV = 32'h0100_0201;
    localparam logic [REG_W-1:0] CTRL_DEV2MEM = 32'h0100_0200;

    localparam logic [1:0] SEL_ADDR  = 2'd0;
    localparam logic [1:0] SEL_BLOCK = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;

    typedef enum logic [1:0] {
        LN_NONE,
        LN_RUN,
        LN_REJECT
    } launch_e;

    typedef enum logic {
        DIR_DEV2MEM = 1'b0,
        DIR_MEM2DEV = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        XS_IDLE,
        XS_FETCH,
        XS_DELIVER
    } xstate_e;

    typedef struct packed {
        launch_e           kind;
        dir_e              dir;
        logic [REG_W-1:0]  words;
    } launch_t;

    function automatic logic [REG_W-1:0] word_total(input logic [REG_W-1:0] blk);
        logic [REG_W-1:0] hi_ext;
        logic [REG_W-1:0] lo_ext;
        hi_ext = {{HALF_W{1'b0}}, blk[REG_W-1:HALF_W]};
        lo_ext = {{HALF_W{1'b0}}, blk[HALF_W-1:0]};
        return hi_ext * lo_ext;
    endfunction

    function automatic logic [REG_W-1:0] align_word(input logic [REG_W-1:0] a);
        return {a[REG_W-1:2], 2'b00};
    endfunction

endpackage

// File: rtl/dma_launch_dec.sv
module dma_launch_dec
    import blk_dma_pkg::*;
(
    input  logic [REG_W-1:0] ctrl_val,
    input  logic [REG_W-1:0] blk_val,
    output launch_t          info
);
    logic [REG_W-1:0] total;
    logic             known;

    always_comb begin
        total = word_total(blk_val);
        known = (ctrl_val == CTRL_MEM2DEV) || (ctrl_val == CTRL_DEV2MEM);
        info.words = total;
        info.dir   = dir_e'(ctrl_val[DIR_BIT]);
        if (!ctrl_val[BUSY_BIT]) begin
            info.kind = LN_NONE;
        end else if (known && (total != '0)) begin
            info.kind = LN_RUN;
        end else begin
            info.kind = LN_REJECT;
        end
    end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import blk_dma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  launch_e          wr_kind,
    input  logic             eng_step,
    input  logic             eng_finish,
    output logic [REG_W-1:0] addr_q,
    output logic [REG_W-1:0] blk_q,
    output logic [REG_W-1:0] ctrl_q,
    output logic             start,
    output logic             abort_req,
    output logic             irq_q
);
    localparam logic [REG_W-1:0] BUSY_MASK = REG_W'(1) << BUSY_BIT;
    localparam logic [REG_W-1:0] ADDR_STEP = REG_W'(WORD_BYTES);

    logic busy;
    logic ctrl_wr;

    assign busy      = ctrl_q[BUSY_BIT];
    assign ctrl_wr   = wr_en && (wr_sel == SEL_CTRL);
    assign start     = ctrl_wr && !busy && (wr_kind == LN_RUN);
    assign abort_req = ctrl_wr && busy && !wr_data[BUSY_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            blk_q  <= '0;
            ctrl_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (!busy) begin
                if (wr_en) begin
                    case (wr_sel)
                        SEL_ADDR:  addr_q <= wr_data;
                        SEL_BLOCK: blk_q  <= wr_data;
                        SEL_CTRL: begin
                            case (wr_kind)
                                LN_RUN: begin
                                    ctrl_q <= wr_data;
                                    addr_q <= align_word(addr_q);
                                end
                                LN_REJECT: begin
                                    ctrl_q <= wr_data & ~BUSY_MASK;
                                    addr_q <= align_word(addr_q);
                                    irq_q  <= 1'b1;
                                end
                                default: ctrl_q <= wr_data;
                            endcase
                        end
                        default: ;
                    endcase
                end
            end else begin
                if (eng_step) begin
                    addr_q <= addr_q + ADDR_STEP;
                end
                if (eng_finish) begin
                    ctrl_q[BUSY_BIT] <= 1'b0;
                    irq_q            <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
    import blk_dma_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  dir_e             start_dir,
    input  logic [REG_W-1:0] start_words,
    input  logic             abort_req,
    input  logic             mem_ready,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             pout_ready,
    input  logic             pin_valid,
    input  logic [DW-1:0]    pin_data,
    output logic             mem_req,
    output logic             mem_we,
    output logic [DW-1:0]    mem_wdata,
    output logic             pout_valid,
    output logic [DW-1:0]    pout_data,
    output logic             pin_ready,
    output logic             step,
    output logic             finish
);
    xstate_e          st_q;
    dir_e             dir_q;
    logic [REG_W-1:0] remain_q;
    logic             abort_q;
    logic [DW-1:0]    hold_q;

    logic to_dev;
    logic fetch_hs;
    logic deliver_hs;
    logic last_word;

    assign to_dev = (dir_q == DIR_MEM2DEV);

    always_comb begin
        mem_req    = ((st_q == XS_FETCH) && to_dev) || ((st_q == XS_DELIVER) && !to_dev);
        mem_we     = (st_q == XS_DELIVER) && !to_dev;
        mem_wdata  = hold_q;
        pout_valid = (st_q == XS_DELIVER) && to_dev;
        pout_data  = hold_q;
        pin_ready  = (st_q == XS_FETCH) && !to_dev;
        fetch_hs   = (st_q == XS_FETCH) && (to_dev ? mem_ready : pin_valid);
        deliver_hs = (st_q == XS_DELIVER) && (to_dev ? pout_ready : mem_ready);
        last_word  = (remain_q == REG_W'(1)) || abort_q || abort_req;
        step       = deliver_hs;
        finish     = deliver_hs && last_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= XS_IDLE;
            dir_q    <= DIR_DEV2MEM;
            remain_q <= '0;
            abort_q  <= 1'b0;
            hold_q   <= '0;
        end else begin
            case (st_q)
                XS_IDLE: begin
                    if (start) begin
                        st_q     <= XS_FETCH;
                        dir_q    <= start_dir;
                        remain_q <= start_words;
                        abort_q  <= 1'b0;
                    end
                end
                XS_FETCH: begin
                    if (abort_req) begin
                        abort_q <= 1'b1;
                    end
                    if (fetch_hs) begin
                        hold_q <= to_dev ? mem_rdata : pin_data;
                        st_q   <= XS_DELIVER;
                    end
                end
                XS_DELIVER: begin
                    if (abort_req) begin
                        abort_q <= 1'b1;
                    end
                    if (deliver_hs) begin
                        remain_q <= remain_q - REG_W'(1);
                        st_q     <= last_word ? XS_IDLE : XS_FETCH;
                    end
                end
                default: st_q <= XS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/blk_dma_chan.sv
module blk_dma_chan
    import blk_dma_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr_en,
    input  logic [1:0]       cfg_wr_sel,
    input  logic [REG_W-1:0] cfg_wr_data,
    output logic [REG_W-1:0] addr_reg,
    output logic [REG_W-1:0] blk_reg,
    output logic [REG_W-1:0] ctrl_reg,
    output logic             mem_req,
    output logic             mem_we,
    output logic [REG_W-1:0] mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_ready,
    input  logic [DW-1:0]    mem_rdata,
    output logic             pout_valid,
    output logic [DW-1:0]    pout_data,
    input  logic             pout_ready,
    input  logic             pin_valid,
    input  logic [DW-1:0]    pin_data,
    output logic             pin_ready,
    output logic             irq
);
    launch_t launch_info;
    logic    start;
    logic    abort_req;
    logic    eng_step;
    logic    eng_finish;

    dma_launch_dec u_dec (
        .ctrl_val (cfg_wr_data),
        .blk_val  (blk_reg),
        .info     (launch_info)
    );

    dma_chan_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (cfg_wr_en),
        .wr_sel     (cfg_wr_sel),
        .wr_data    (cfg_wr_data),
        .wr_kind    (launch_info.kind),
        .eng_step   (eng_step),
        .eng_finish (eng_finish),
        .addr_q     (addr_reg),
        .blk_q      (blk_reg),
        .ctrl_q     (ctrl_reg),
        .start      (start),
        .abort_req  (abort_req),
        .irq_q      (irq)
    );

    dma_xfer_engine #(.DW(DW)) u_eng (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_dir   (launch_info.dir),
        .start_words (launch_info.words),
        .abort_req   (abort_req),
        .mem_ready   (mem_ready),
        .mem_rdata   (mem_rdata),
        .pout_ready  (pout_ready),
        .pin_valid   (pin_valid),
        .pin_data    (pin_data),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_wdata   (mem_wdata),
        .pout_valid  (pout_valid),
        .pout_data   (pout_data),
        .pin_ready   (pin_ready),
        .step        (eng_step),
        .finish      (eng_finish)
    );

    assign mem_addr = addr_reg;
endmodule

// File: rtl/blk_dma_chan_chk.sv
module blk_dma_chan_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          irq,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ready,
    input logic [31:0]   mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          pout_valid,
    input logic          pout_ready,
    input logic [DW-1:0] pout_data,
    input logic          pin_ready,
    input logic [31:0]   addr_reg
);
    // R6: the interrupt pulse never overlaps a running job
    assert_irq_idle_R6: assert property (@(posedge clk) disable iff (rst)
        irq |-> !busy);

    // R11: a stalled memory request keeps its address, direction and data
    assert_mem_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R11: a stalled outbound word keeps its data
    assert_pout_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (pout_valid && !pout_ready) |=> (pout_valid && $stable(pout_data)));

    // R3: every memory access is word aligned
    assert_aligned_R3: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R3: while busy the address only holds or advances by one word
    assert_addr_step_R3: assert property (@(posedge clk) disable iff (rst)
        busy |=> ((addr_reg == $past(addr_reg)) || (addr_reg == $past(addr_reg) + 32'd4)));

    // R4, R5: one port activity at a time
    assert_one_port_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_req, pout_valid, pin_ready}));

    // R7, R12: no port activity without a running job
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !pout_valid && !pin_ready));
endmodule

bind blk_dma_chan blk_dma_chan_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (ctrl_reg[24]),
    .irq        (irq),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ready  (mem_ready),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .pout_valid (pout_valid),
    .pout_ready (pout_ready),
    .pout_data  (pout_data),
    .pin_ready  (pin_ready),
    .addr_reg   (addr_reg)
);

// File: tb/blk_dma_chan_tb.sv
module blk_dma_chan_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_wr_sel = 2'd0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] addr_reg, blk_reg, ctrl_reg;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ready = 1'b0;
    logic        pout_valid;
    logic [31:0] pout_data;
    logic        pout_ready = 1'b0;
    logic        pin_valid = 1'b0;
    logic [31:0] pin_data = '0;
    logic        pin_ready;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    logic [31:0] mem [0:63];
    logic [31:0] pout_buf [0:63];
    bit  stall_mode = 1'b0;
    bit  hold_mem   = 1'b0;
    int  neg_idx    = 0;
    int  acc_cnt    = 0;
    int  addr_bad   = 0;
    int  pout_cnt   = 0;
    int  pin_cnt    = 0;
    int  last_hs    = -10;
    logic [31:0] acc_base = '0;

    always #10 clk = ~clk;

    blk_dma_chan u_dut (
        .clk(clk), .rst(rst),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
        .addr_reg(addr_reg), .blk_reg(blk_reg), .ctrl_reg(ctrl_reg),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .pout_valid(pout_valid), .pout_data(pout_data), .pout_ready(pout_ready),
        .pin_valid(pin_valid), .pin_data(pin_data), .pin_ready(pin_ready),
        .irq(irq)
    );

    assign mem_rdata = mem[mem_addr[7:2]];

    // Port models: handshakes decided at the falling edge take effect at the next rising edge
    always @(negedge clk) begin
        neg_idx++;
        pin_data   = 32'hA500_0000 + 32'(pin_cnt);
        mem_ready  = !hold_mem && !(stall_mode && (neg_idx % 3 == 1));
        pout_ready = !(stall_mode && (neg_idx % 4 == 2));
        pin_valid  = !(stall_mode && (neg_idx % 5 == 3));
        if (mem_req && mem_ready) begin
            if (mem_addr != acc_base + 32'(4 * acc_cnt)) addr_bad++;
            acc_cnt++;
            if (mem_we) begin
                mem[mem_addr[7:2]] = mem_wdata;
                last_hs = neg_idx;
            end
        end
        if (pout_valid && pout_ready) begin
            pout_buf[pout_cnt] = pout_data;
            pout_cnt++;
            last_hs = neg_idx;
        end
        if (pin_valid && pin_ready) pin_cnt++;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, act, exp);
    endtask

    task automatic clear_counts(input logic [31:0] base);
        acc_base = base;
        acc_cnt  = 0;
        addr_bad = 0;
        pout_cnt = 0;
        pin_cnt  = 0;
        last_hs  = -10;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_sel  = sel;
        cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en   = 1'b0;
        #1;
    endtask

    task automatic wait_done(input string req, input logic [31:0] exp_addr, input logic [31:0] exp_ctrl);
        int n = 0;
        while (irq !== 1'b1 && n < 2000) begin
            @(negedge clk);
            #1;
            n++;
        end
        chk_eq({req, " irq seen"}, {31'd0, irq}, 32'd1);
        chk_eq("R6 irq one cycle after last word", 32'(neg_idx - last_hs), 32'd1);
        chk_eq("R6 busy clear at completion", {31'd0, ctrl_reg[24]}, 32'd0);
        chk_eq("R6 final address", addr_reg, exp_addr);
        chk_eq({req, " control readback"}, ctrl_reg, exp_ctrl);
        @(negedge clk);
        #1;
        chk_eq("R6 irq is a single pulse", {31'd0, irq}, 32'd0);
    endtask

    task automatic test_reset();
        chk_eq("R1 address reset", addr_reg, 32'd0);
        chk_eq("R1 block reset", blk_reg, 32'd0);
        chk_eq("R1 control reset", ctrl_reg, 32'd0);
        chk_eq("R1 no requests", {29'd0, mem_req, pout_valid, pin_ready}, 32'd0);
        chk_eq("R1 irq low", {31'd0, irq}, 32'd0);
    endtask

    task automatic test_mem2dev(input logic [31:0] start_addr, input logic [15:0] hi,
                                input logic [15:0] lo, input bit stalls);
        int          nw   = int'(hi) * int'(lo);
        logic [31:0] base = {start_addr[31:2], 2'b00};
        int          bad  = 0;
        for (int k = 0; k < nw; k++) mem[base[7:2] + k] = 32'hC0DE_0000 + (base << 8) + 32'(k);
        stall_mode = stalls;
        clear_counts(base);
        wr(2'd0, start_addr);
        wr(2'd1, {hi, lo});
        wr(2'd2, 32'h0100_0201);
        wait_done("R4", base + 32'(4 * nw), 32'h0000_0201);
        chk_eq("R2 words delivered", 32'(pout_cnt), 32'(nw));
        for (int k = 0; k < nw; k++)
            if (pout_buf[k] !== 32'hC0DE_0000 + (base << 8) + 32'(k)) bad++;
        chk_eq("R4 R11 delivered data order", 32'(bad), 32'd0);
        chk_eq("R3 aligned ascending addresses", 32'(addr_bad), 32'd0);
        stall_mode = 1'b0;
    endtask

    task automatic test_dev2mem(input logic [31:0] start_addr, input logic [15:0] hi,
                                input logic [15:0] lo, input bit stalls);
        int          nw   = int'(hi) * int'(lo);
        logic [31:0] base = {start_addr[31:2], 2'b00};
        int          bad  = 0;
        for (int k = 0; k < nw; k++) mem[base[7:2] + k] = 32'h0;
        stall_mode = stalls;
        clear_counts(base);
        wr(2'd0, start_addr);
        wr(2'd1, {hi, lo});
        wr(2'd2, 32'h0100_0200);
        wait_done("R5", base + 32'(4 * nw), 32'h0000_0200);
        chk_eq("R2 words taken from peripheral", 32'(pin_cnt), 32'(nw));
        for (int k = 0; k < nw; k++)
            if (mem[base[7:2] + k] !== 32'hA500_0000 + 32'(k)) bad++;
        chk_eq("R5 memory contents", 32'(bad), 32'd0);
        chk_eq("R3 aligned ascending addresses", 32'(addr_bad), 32'd0);
        stall_mode = 1'b0;
    endtask

    task automatic test_no_run(input string req, input logic [31:0] blk,
                               input logic [31:0] ctrl, input logic [31:0] exp_ctrl, input bit exp_irq);
        clear_counts(32'h0);
        wr(2'd0, 32'h0000_0031);
        wr(2'd1, blk);
        wr(2'd2, ctrl);
        chk_eq({req, " control readback"}, ctrl_reg, exp_ctrl);
        chk_eq({req, " irq after write"}, {31'd0, irq}, {31'd0, exp_irq});
        chk_eq({req, " address"}, addr_reg, exp_irq ? 32'h0000_0030 : 32'h0000_0031);
        repeat (4) @(negedge clk);
        #1;
        chk_eq({req, " no port access"}, 32'(acc_cnt + pout_cnt + pin_cnt), 32'd0);
        chk_eq({req, " irq quiet"}, {31'd0, irq}, 32'd0);
    endtask

    task automatic test_busy_writes();
        int nw = 6;
        for (int k = 0; k < nw; k++) mem[16 + k] = 32'h7700_0000 + 32'(k);
        stall_mode = 1'b1;
        clear_counts(32'h40);
        wr(2'd0, 32'h40);
        wr(2'd1, 32'h0002_0003);
        wr(2'd2, 32'h0100_0201);
        wr(2'd0, 32'h0000_0004);
        wr(2'd1, 32'h0001_0001);
        wr(2'd2, 32'h0100_0200);
        chk_eq("R9 block unchanged while busy", blk_reg, 32'h0002_0003);
        chk_eq("R9 control unchanged while busy", ctrl_reg, 32'h0100_0201);
        wait_done("R9", 32'h40 + 32'(4 * nw), 32'h0000_0201);
        chk_eq("R9 full length", 32'(pout_cnt), 32'(nw));
        stall_mode = 1'b0;
    endtask

    task automatic test_abort();
        mem[8] = 32'hABCD_0001;
        hold_mem = 1'b1;
        clear_counts(32'h20);
        wr(2'd0, 32'h20);
        wr(2'd1, 32'h0001_0008);
        wr(2'd2, 32'h0100_0201);
        repeat (2) @(negedge clk);
        #1;
        chk_eq("R10 busy before abort", {31'd0, ctrl_reg[24]}, 32'd1);
        wr(2'd2, 32'h0000_0201);
        chk_eq("R10 still busy while word in flight", {31'd0, ctrl_reg[24]}, 32'd1);
        hold_mem = 1'b0;
        wait_done("R10", 32'h24, 32'h0000_0201);
        chk_eq("R10 exactly one word", 32'(pout_cnt), 32'd1);
        chk_eq("R10 word data", pout_buf[0], 32'hABCD_0001);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=done", neg_idx);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < 64; k++) mem[k] = 32'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        test_reset();
        test_mem2dev(32'h0000_0043, 16'd3, 16'd4, 1'b0);
        test_mem2dev(32'h0000_0010, 16'd1, 16'd5, 1'b1);
        test_dev2mem(32'h0000_0082, 16'd2, 16'd5, 1'b1);
        test_dev2mem(32'h0000_00C0, 16'd4, 16'd1, 1'b0);
        test_no_run("R7", 32'h0001_0004, 32'h0100_0001, 32'h0000_0001, 1'b1);
        test_no_run("R8", 32'h0000_0005, 32'h0100_0201, 32'h0000_0201, 1'b1);
        test_no_run("R12", 32'h0001_0004, 32'h0000_0200, 32'h0000_0200, 1'b0);
        test_busy_writes();
        test_abort();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule